// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of device functions onto four shared interrupt lines. Every device presents four request pins. The block records the last level it saw on each pin and reacts only when a level changes. Each shared line keeps a count of the pins currently holding it active. The line is driven high whenever that count is above zero. The result behaves like a wired-OR of all the pins routed to the line. An asserting pin that is already high, or a releasing pin that is already low, has no effect on any count.

Pins are routed to lines by a rotation based on the device index. This spreads the pin-0 requests of neighbouring devices across different lines. All pin changes seen at one clock edge are folded into the counters at that same edge, even when several of them land on one line.

Top module: `irq_share_agg`

## Requirements
- R1: While reset is low, and after reset is released, every counter and every recorded pin level is zero, so all four lines are low.
- R2: Pin p of device d is input bit index d*4+p and drives line (p + d) mod 4; line j is output bit j.
- R3: A line is high exactly when at least one pin routed to it is high.
- R4: A pin change reaches the lines one clock after the edge that samples it; there is no combinational path from pins to lines.
- R5: Holding every pin at its current level for any number of cycles leaves every line unchanged.
- R6: Several pins changing at the same edge, including rises and falls that land on one line, are all applied at that edge.
- R7: A counter never goes below zero. A decrement that would take it below zero is clamped at zero and flagged internally.
- R8: A line that several pins hold high stays high until the last of those pins is released, and goes low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_DEV*4 | Request levels, bit d*4+p is pin p of device d |
| line_out | output | 4 | Shared interrupt lines, high while any routed pin is active |

## Verification
The hardest state to reach from the ports is a line whose counter receives increments and decrements in the same cycle from different devices. A double count or a lost update only shows up later, when the final holder releases the line. The bench reaches this state by stepping through every pin pattern of a four-device configuration in binary order. Each binary carry flips many bits at once across devices. A second pass in Gray order then isolates single-pin changes. In both passes every line is compared with a reference computed from the pattern, and a deliberate stack-up and staggered release on one line confirms that the line drops only when its last holder releases.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
    localparam int LINES    = 4;
    localparam int PINS_DEV = 4;

    // Line that pin 'pin' of device 'dev' is routed to
    function automatic int route_line(input int dev, input int pin);
        return (dev + pin) % LINES;
    endfunction

    // Pin of device 'dev' that feeds line 'line'
    function automatic int feeding_pin(input int dev, input int line);
        return (line + LINES - (dev % LINES)) % LINES;
    endfunction
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
    parameter int PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] lvl_i,
    output logic [PINS-1:0] rise_o,
    output logic [PINS-1:0] fall_o
);
    typedef struct packed {
        logic [PINS-1:0] lvl;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        rise_o   = lvl_i & ~st_q.lvl;
        fall_o   = ~lvl_i & st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_line_count.sv
module irq_line_count #(
    parameter int SRCS  = 4,
    parameter int CNT_W = $clog2(SRCS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCS-1:0] inc_i,
    input  logic [SRCS-1:0] dec_i,
    output logic            line_o,
    output logic            uflow_o
);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t             st_d, st_q;
    logic [SUM_W-1:0] ups, dns, total;

    always_comb begin
        st_d    = st_q;
        ups     = '0;
        dns     = '0;
        uflow_o = 1'b0;
        for (int i = 0; i < SRCS; i++) begin
            ups = ups + {{CNT_W{1'b0}}, inc_i[i]};
            dns = dns + {{CNT_W{1'b0}}, dec_i[i]};
        end
        total = {1'b0, st_q.cnt} + ups;
        if (dns > total) begin
            st_d.cnt = '0;
            uflow_o  = 1'b1;
        end else begin
            total    = total - dns;
            st_d.cnt = total[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = (st_q.cnt != '0);
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
    import irq_share_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_DEV*PINS_DEV-1:0] pin_lvl,
    output logic [LINES-1:0]           line_out
);
    localparam int CNT_W = $clog2(NUM_DEV + 1);

    logic [NUM_DEV-1:0][PINS_DEV-1:0] rise_w, fall_w;
    logic [LINES-1:0][NUM_DEV-1:0]    inc_w, dec_w;
    logic [LINES-1:0]                 uflow;

    for (genvar gd = 0; gd < NUM_DEV; gd++) begin : g_dev
        irq_pin_track #(.PINS(PINS_DEV)) u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (pin_lvl[gd*PINS_DEV +: PINS_DEV]),
            .rise_o (rise_w[gd]),
            .fall_o (fall_w[gd])
        );
    end

    for (genvar gl = 0; gl < LINES; gl++) begin : g_line
        for (genvar gd = 0; gd < NUM_DEV; gd++) begin : g_src
            localparam int PSEL = feeding_pin(gd, gl);
            assign inc_w[gl][gd] = rise_w[gd][PSEL];
            assign dec_w[gl][gd] = fall_w[gd][PSEL];
        end

        irq_line_count #(.SRCS(NUM_DEV), .CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc_w[gl]),
            .dec_i   (dec_w[gl]),
            .line_o  (line_out[gl]),
            .uflow_o (uflow[gl])
        );
    end
endmodule

// File: rtl/irq_share_chk.sv
module irq_share_chk #(
    parameter int NUM_DEV = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_DEV*4-1:0] pin_lvl,
    input logic [3:0]           line_out,
    input logic [3:0]           uflow
);
    logic [3:0] exp_now, exp_q;
    logic       past_ok;

    always_comb begin
        exp_now = '0;
        for (int d = 0; d < NUM_DEV; d++)
            for (int p = 0; p < 4; p++)
                if (pin_lvl[d*4+p]) exp_now[(d+p)%4] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            exp_q   <= exp_now;
            past_ok <= 1'b1;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> (line_out == '0)); // R1
    AST_LINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) line_out == exp_q); // R3
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (past_ok && $stable(pin_lvl)) |=> $stable(line_out)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) uflow == '0); // R7
    AST_ALL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (pin_lvl == '0) |=> (line_out == '0)); // R8
endmodule

bind irq_share_agg irq_share_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .line_out (line_out),
    .uflow    (uflow)
);

// File: tb/sim_irq_share_agg.sv
module sim_irq_share_agg;
    localparam int CLK_P = 10;
    localparam int NDEV  = 4;
    localparam int W     = NDEV * 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_lvl = '0;
    logic [3:0]   line_out;
    int           n_chk = 0;
    int           n_fail = 0;

    irq_share_agg #(.NUM_DEV(NDEV)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .line_out(line_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [3:0] exp_lines(input logic [W-1:0] pat);
        logic [3:0] e = '0;
        for (int d = 0; d < NDEV; d++)
            for (int p = 0; p < 4; p++)
                if (pat[d*4+p]) e[(d+p)%4] = 1'b1;
        return e;
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: line_out=%b expected=%b pins=%h", req, act, exp, pin_lvl);
        end
    endtask

    // Drive at a falling edge, check one full cycle later
    task automatic step(input logic [W-1:0] pat, input string req);
        pin_lvl = pat;
        @(negedge clk);
        check(line_out, exp_lines(pat), req);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        check(line_out, 4'b0000, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out, 4'b0000, "R1 after reset");

        // R4: no change before the sampling edge, visible after it
        pin_lvl = 16'h0001;
        #1 check(line_out, 4'b0000, "R4 before edge");
        @(negedge clk);
        check(line_out, 4'b0001, "R4 after edge");
        step('0, "R4 release");

        // R2: each pin alone lands on (pin + dev) mod 4
        for (int b = 0; b < W; b++) begin
            pin_lvl = W'(1) << b;
            @(negedge clk);
            check(line_out, 4'b0001 << (((b % 4) + (b / 4)) % 4), "R2 routing");
        end
        step('0, "R2 clear");

        // R5: steady levels, repeated many cycles
        step(16'h2481, "R5 set");
        for (int k = 0; k < 6; k++) step(16'h2481, "R5 hold");
        step(16'h0000, "R5 clear");
        for (int k = 0; k < 4; k++) step(16'h0000, "R5 hold low");

        // R6: pins feeding line 0 are bits 0, 7, 10, 13
        step(16'h2481, "R6 four rises on one line");
        step(16'h2002 | 16'h0000, "R6 three falls and a rise same edge");
        step(16'h0080 | 16'h0002, "R6 mixed rise and fall line 0");

        // R8: stack line 0, release one holder at a time
        step('0, "R8 start");
        step(16'h0001, "R8 add 1");
        step(16'h0081, "R8 add 2");
        step(16'h0481, "R8 add 3");
        step(16'h2481, "R8 add 4");
        step(16'h2480, "R8 drop 1");
        check(line_out, 4'b0001, "R8 still held");
        step(16'h2400, "R8 drop 2");
        step(16'h2000, "R8 drop 3");
        check(line_out, 4'b0001, "R8 last holder");
        step(16'h0000, "R8 drop last");
        check(line_out, 4'b0000, "R8 released");

        // R3: exhaustive sweep, binary order (multi-bit changes)
        for (int i = 0; i < (1 << W); i++) step(W'(i), "R3 binary sweep");
        // R3: Gray order (single-bit changes)
        for (int i = 0; i < (1 << W); i++) begin
            v = W'(i);
            step(v ^ (v >> 1), "R3 gray sweep");
        end

        // R7: full assert and full release after heavy traffic
        step('0, "R7 clear");
        step('1, "R7 all high");
        step('0, "R7 all low");
        step(16'h8421, "R7 reuse after release");
        step('0, "R7 final clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule